// File: doc/BRIEF.md
# Two-Wire Bus Recovery Clock Burst Generator

When a slave on a two-wire serial bus stops in the middle of a byte, it can hold the data line low and keep the bus from working. This block clears that state by clocking the stuck slave through sixteen SCL pulses, which is enough for it to shift out what it holds and let go of SDA. Software writes a one to the trigger bit of the control register. The block then drives a burst of sixteen SCL pulses through an open-drain style enable. Each pulse has a low phase followed by a high phase.

Two 7-bit settings set the length of each phase separately. A setting S gives a phase of (S+1)*8+8 cycles of the oscillator clock, which is the clock the block runs on. The block copies both settings when a burst starts. After the last high phase it releases SCL, goes back to idle and sends a one-cycle done pulse to the interrupt cause logic. The trigger bit holds no state, so a read of it always returns zero.

Top module: `scl_rec_top`

## Requirements
- R1: After reset, `scl_oe` and `rst_done` are 0. The high-width setting reads 0x2D and the low-width setting reads 0x37.
- R2: When the block is idle, a write to address 0 with data bit 0 set starts a burst. `scl_oe` is 1 in the cycle that follows that clock edge.
- R3: A burst contains exactly 16 pulses. Each pulse is a low phase (`scl_oe`=1) followed by a high phase (`scl_oe`=0).
- R4: Every low phase lasts (S_L+1)*8+8 clock cycles. S_L is bits 6:0 of address 2.
- R5: Every high phase lasts (S_H+1)*8+8 clock cycles. S_H is bits 6:0 of address 1. This includes the high phase that ends the burst.
- R6: `rst_done` is 1 for exactly one cycle, the cycle right after the last high phase. In that cycle and afterwards, SCL stays released (`scl_oe`=0) until a new start.
- R7: A read of address 0 always returns 0x00, including while a burst is running.
- R8: Read data is registered and appears in the cycle after `rd_en`. The width settings read back in bits 6:0 with bit 7 at 0. Address 3 reads 0x00.
- R9: A start write that arrives while a burst is running has no effect on that burst.
- R10: Writes to the width settings during a burst do not change the burst in progress. They take effect from the next burst.
- R11: Writing 0 to bit 0 of address 0 does not start a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all timing counts its cycles |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 high width, 2 low width |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read data |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| rst_done | output | 1 | One-cycle pulse when the burst has finished |

## Verification
Bursts are run with several width pairs: the reset defaults, the smallest widths with high wider than low, and low wider than high. A swapped or shared setting therefore shows up as a wrong phase length. One burst receives a second trigger and new width values while it is running. This separates sampling at the start of a burst from reading the settings live, and it shows whether a restart is wrongly accepted. A write of zero to the trigger while idle, and a trigger that follows directly after a done pulse, test the start condition at its edges.

// File: rtl/scl_rec_pkg.sv
package scl_rec_pkg;

  localparam int ADR_CTRL = 0;
  localparam int ADR_HIGH = 1;
  localparam int ADR_LOW  = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } burst_st_t;

  // phase length in oscillator cycles for a width setting s
  function automatic int unsigned phase_cycles(input int unsigned s);
    return (s + 1) * 8 + 8;
  endfunction

endpackage

// File: rtl/scl_rec_regs.sv
module scl_rec_regs #(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  parameter int W_SET    = 7,
  parameter int HIGH_DEF = 45,
  parameter int LOW_DEF  = 55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [W_SET-1:0]  high_set,
  output logic [W_SET-1:0]  low_set,
  output logic              start_req
);
  import scl_rec_pkg::*;

  localparam int PAD_W = DATA_W - W_SET;

  logic [W_SET-1:0]  high_q, low_q;
  logic [DATA_W-1:0] rd_q, rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      high_q <= W_SET'(HIGH_DEF);
      low_q  <= W_SET'(LOW_DEF);
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ADR_HIGH)) high_q <= wr_data[W_SET-1:0];
      if (wr_addr == ADDR_W'(ADR_LOW))  low_q  <= wr_data[W_SET-1:0];
    end
  end

  // the trigger bit keeps no state, so it always reads back as zero
  always_comb begin
    rd_mux = '0;
    if (rd_addr == ADDR_W'(ADR_HIGH)) rd_mux = {{PAD_W{1'b0}}, high_q};
    else if (rd_addr == ADDR_W'(ADR_LOW)) rd_mux = {{PAD_W{1'b0}}, low_q};
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data   = rd_q;
  assign high_set  = high_q;
  assign low_set   = low_q;
  assign start_req = wr_en && (wr_addr == ADDR_W'(ADR_CTRL)) && wr_data[0];

endmodule

// File: rtl/scl_rec_timer.sv
module scl_rec_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/scl_rec_seq.sv
module scl_rec_seq #(
  parameter int W_SET    = 7,
  parameter int N_PULSES = 16,
  parameter int CNT_W    = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [W_SET-1:0] high_set,
  input  logic [W_SET-1:0] low_set,
  input  logic             expired,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             scl_oe,
  output logic             done
);
  import scl_rec_pkg::*;

  localparam int PC_W = $clog2(N_PULSES + 1);
  localparam logic [PC_W-1:0] LAST = PC_W'(N_PULSES - 1);

  burst_st_t        st_q;
  logic [PC_W-1:0]  pcnt_q;
  logic [CNT_W-1:0] lo_len_q, hi_len_q;
  logic [CNT_W-1:0] lo_len_new, hi_len_new;
  logic             oe_q, done_q;

  assign lo_len_new = CNT_W'(phase_cycles(32'(low_set)) - 1);
  assign hi_len_new = CNT_W'(phase_cycles(32'(high_set)) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      pcnt_q   <= '0;
      lo_len_q <= '0;
      hi_len_q <= '0;
      oe_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_req) begin
          st_q     <= ST_LOW;
          oe_q     <= 1'b1;
          pcnt_q   <= '0;
          lo_len_q <= lo_len_new;
          hi_len_q <= hi_len_new;
        end
        ST_LOW: if (expired) begin
          st_q <= ST_HIGH;
          oe_q <= 1'b0;
        end
        ST_HIGH: if (expired) begin
          if (pcnt_q == LAST) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
            st_q   <= ST_LOW;
            oe_q   <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    load     = 1'b0;
    load_val = '0;
    unique case (st_q)
      ST_IDLE: if (start_req) begin
        load     = 1'b1;
        load_val = lo_len_new;
      end
      ST_LOW: if (expired) begin
        load     = 1'b1;
        load_val = hi_len_q;
      end
      ST_HIGH: if (expired && pcnt_q != LAST) begin
        load     = 1'b1;
        load_val = lo_len_q;
      end
      default: ;
    endcase
  end

  assign busy   = (st_q != ST_IDLE);
  assign scl_oe = oe_q;
  assign done   = done_q;

endmodule

// File: rtl/scl_rec_top.sv
module scl_rec_top #(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  parameter int W_SET    = 7,
  parameter int N_PULSES = 16,
  parameter int HIGH_DEF = 45,
  parameter int LOW_DEF  = 55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              scl_oe,
  output logic              rst_done
);

  localparam int MAX_PHASE = ((2 ** W_SET) - 1) * 8 + 16;
  localparam int CNT_W     = $clog2(MAX_PHASE + 1);

  logic [W_SET-1:0] high_set, low_set;
  logic             start_req, expired, load, busy;
  logic [CNT_W-1:0] load_val;

  scl_rec_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .W_SET(W_SET),
    .HIGH_DEF(HIGH_DEF), .LOW_DEF(LOW_DEF)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .high_set(high_set), .low_set(low_set), .start_req(start_req)
  );

  scl_rec_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .expired(expired)
  );

  scl_rec_seq #(.W_SET(W_SET), .N_PULSES(N_PULSES), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start_req(start_req),
    .high_set(high_set), .low_set(low_set), .expired(expired),
    .load(load), .load_val(load_val), .busy(busy),
    .scl_oe(scl_oe), .done(rst_done)
  );

endmodule

// File: rtl/scl_rec_chk.sv
module scl_rec_chk #(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  parameter int N_PULSES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              scl_oe,
  input logic              rst_done,
  input logic              busy
);

  logic        prev_oe;
  int unsigned rises;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_oe <= 1'b0;
      rises   <= 0;
    end else begin
      prev_oe <= scl_oe;
      if (rst_done)               rises <= 0;
      else if (scl_oe && !prev_oe) rises <= rises + 1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!scl_oe && !rst_done));

  // R2
  start_drives_low_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == '0 && wr_data[0] && !busy) |=> scl_oe);

  // R3
  pulse_total_chk: assert property (@(posedge clk) disable iff (rst)
    rst_done |-> (rises == N_PULSES));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    rst_done |=> !rst_done);

  // R6
  done_released_chk: assert property (@(posedge clk) disable iff (rst)
    rst_done |-> (!scl_oe && !busy));

  // R7
  ctrl_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == '0) |=> (rd_data == '0));

endmodule

bind scl_rec_top scl_rec_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_PULSES(N_PULSES)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .scl_oe(scl_oe), .rst_done(rst_done), .busy(busy)
);

// File: tb/test_scl_rec_top.sv
`timescale 1ns/1ps
module test_scl_rec_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       scl_oe, rst_done;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  scl_rec_top i_scl_rec_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .scl_oe(scl_oe), .rst_done(rst_done)
  );

  // ---------------- reference model ----------------
  int  m_hi = 45, m_lo = 55;
  int  m_L = 0, m_H = 0, m_k = 0;
  bit  m_busy = 0, m_done = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_hi = 45; m_lo = 55; m_busy = 0; m_done = 0; m_k = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_k == 16 * (m_L + m_H) - 1) begin
          m_busy = 0; m_done = 1;
        end else m_k++;
      end else if (wr_en && wr_addr == 2'd0 && wr_data[0]) begin
        m_busy = 1; m_k = 0;
        m_L = (m_lo + 1) * 8 + 8;
        m_H = (m_hi + 1) * 8 + 8;
      end
      if (wr_en && wr_addr == 2'd1) m_hi = wr_data[6:0];
      if (wr_en && wr_addr == 2'd2) m_lo = wr_data[6:0];
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (!rst && !finished) begin
    automatic bit exp_oe = m_busy && ((m_k % (m_L + m_H)) < m_L);
    checks++;
    if (scl_oe !== exp_oe) begin
      errors++;
      $display("FAIL R2/R3/R4/R5 scl_oe at %0t: actual=%b expected=%b", $time, scl_oe, exp_oe);
    end
    checks++;
    if (rst_done !== m_done) begin
      errors++;
      $display("FAIL R6 rst_done at %0t: actual=%b expected=%b", $time, rst_done, m_done);
    end
  end

  // ---------------- phase-length monitor ----------------
  int  mon_rises, mon_done, lrun, hrun;
  int  lo_min, lo_max, hi_min, hi_max;
  bit  prev_oe = 0;

  task automatic clear_mon();
    mon_rises = 0; mon_done = 0; lrun = 0; hrun = 0;
    lo_min = 1 << 30; lo_max = 0; hi_min = 1 << 30; hi_max = 0;
  endtask

  always @(negedge clk) if (!rst) begin
    if (scl_oe) begin
      if (!prev_oe) begin
        if (mon_rises > 0) begin
          if (hrun < hi_min) hi_min = hrun;
          if (hrun > hi_max) hi_max = hrun;
        end
        mon_rises++;
        lrun = 1;
      end else lrun++;
    end else begin
      if (prev_oe) begin
        if (lrun < lo_min) lo_min = lrun;
        if (lrun > lo_max) lo_max = lrun;
        hrun = 1;
      end else hrun++;
    end
    if (rst_done) begin
      // final high phase ends at the done cycle
      if (hrun - 1 < hi_min) hi_min = hrun - 1;
      if (hrun - 1 > hi_max) hi_max = hrun - 1;
      mon_done++;
    end
    prev_oe = scl_oe;
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic burst_stats(input string tag, input int sl, input int sh);
    automatic int L = (sl + 1) * 8 + 8;
    automatic int H = (sh + 1) * 8 + 8;
    check("R3", {tag, " pulse count"}, mon_rises, 16);
    check("R4", {tag, " low min"}, lo_min, L);
    check("R4", {tag, " low max"}, lo_max, L);
    check("R5", {tag, " high min"}, hi_min, H);
    check("R5", {tag, " high max"}, hi_max, H);
    check("R6", {tag, " done pulses"}, mon_done, 1);
    check("R6", {tag, " released after"}, int'(scl_oe), 0);
  endtask

  task automatic run_burst(input string tag, input int sl, input int sh);
    clear_mon();
    wr(2'd0, 8'h01);
    wait_cycles(16 * ((sl + 1) * 8 + 8 + (sh + 1) * 8 + 8) + 4);
    burst_stats(tag, sl, sh);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] d;
    clear_mon();
    wait_cycles(3);
    // R1: outputs quiet during reset
    check("R1", "scl_oe in reset", int'(scl_oe), 0);
    check("R1", "done in reset", int'(rst_done), 0);
    rst = 0;
    rd(2'd1, d); check("R1", "high default", d, 8'h2D);
    rd(2'd2, d); check("R1", "low default", d, 8'h37);
    rd(2'd0, d); check("R7", "ctrl read idle", d, 0);
    rd(2'd3, d); check("R8", "unused address", d, 0);

    // R11: writing zero to the trigger starts nothing
    clear_mon();
    wr(2'd0, 8'h00);
    wait_cycles(40);
    check("R11", "no pulses after zero write", mon_rises, 0);

    // R2: start timing, first cycle after the write edge
    @(negedge clk);
    wr_en = 1; wr_addr = 2'd0; wr_data = 8'h01;
    clear_mon();
    @(negedge clk);
    wr_en = 0;
    check("R2", "scl_oe one cycle after start", int'(scl_oe), 1);
    rd(2'd0, d); check("R7", "ctrl read busy", d, 0);
    wait_cycles(16 * (376 + 456) + 2);
    burst_stats("defaults", 55, 45);

    // R8: readback masks bit 7
    wr(2'd1, 8'h81); rd(2'd1, d); check("R8", "high readback", d, 8'h01);
    wr(2'd2, 8'h80); rd(2'd2, d); check("R8", "low readback", d, 8'h00);
    run_burst("narrow", 0, 1);

    // R9/R10: restart and width writes while busy
    wr(2'd1, 8'h00); wr(2'd2, 8'h03);
    clear_mon();
    wr(2'd0, 8'h01);
    wait_cycles(100);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h05);
    wr(2'd2, 8'h02);
    wait_cycles(16 * (40 + 16) + 2 - 106);
    burst_stats("R9 R10 busy writes", 3, 0);
    rd(2'd1, d); check("R10", "new high stored", d, 5);
    run_burst("R10 next burst", 2, 5);

    // R2: trigger directly after done is accepted
    clear_mon();
    wr(2'd0, 8'h01);
    wait_cycles(16 * (32 + 56) - 1);
    @(negedge clk);
    wr_en = 1; wr_addr = 2'd0; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 0;
    check("R2", "back-to-back start", int'(scl_oe), 1);
    wait_cycles(16 * (32 + 56) + 4);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule